// File: doc/BRIEF.md
# Stop-Mode Wake-Up Source Controller

This block decides when a sleeping controller core may leave STOP mode. A control register picks one wake source from a small encoded set: a single port pin, or a reduction over the low port pins. The same register sets the level that counts as active and chooses between a fast wake and a wake followed by a counted reset hold. A two-bit extension register adds AND-reduction sources. It is consulted only when the main source field selects no pin.

Software enters STOP by pulsing `stop_enter`. From then on the block watches its selected source through a two-flop synchroniser. When the source has been active long enough, the block emits a one-cycle `wake_req`. In delayed mode it then holds `core_hold` high for a programmed number of cycles. A status bit shows whether the last start was cold (power-on) or warm (set on STOP entry). All pins are plain control and status signals. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `stop_wake_ctrl`

## Requirements
- R1: After `por_n` is released, `wake_req` and `core_hold` are 0 and `cfg_rdata` reads 8'h20: polarity 0, delay bit 1, source 000, status 0, bits 1..0 always 0. The extension field resets to 00.
- R2: Control bits 4..2 select the source: 000 none (extension decides), 001 p3_in[0], 010 p3_in[1], 011 p3_in[2], 100 p3_in[3], 101 p2_in[7], 110 NOR of p2_in[3:0], 111 NOR of p2_in[7:0].
- R3: Control bit 6 = 1 makes a high source value active. Bit 6 = 0 makes a low value active.
- R4: The extension field (`ext_wdata[1:0]`) applies only when bits 4..2 are 000: 01 AND of p2_in[3:0], 10 AND of p2_in[7:0], 00 and 11 give no source, so no wake at any polarity.
- R5: With control bit 5 = 1, one active cycle wakes the core. `core_hold` rises together with `wake_req` and stays high for exactly DLY_CYCLES cycles.
- R6: With control bit 5 = 0, the source must be active for FAST_QUAL consecutive cycles before the wake. A shorter pulse does not wake, and `core_hold` stays 0.
- R7: Status bit 7 becomes 1 at STOP entry and returns to 0 only through `por_n`.
- R8: The source is evaluated only while STOP is active. `wake_req` lasts one cycle and ends STOP.
- R9: Pins pass through two flops. With STOP already active, a pin change seen at the input gives `wake_req` 2 + N cycles later, where N is 1 in delayed mode and FAST_QUAL in fast mode. A STOP entry with the source already active gives `wake_req` 1 + N cycles after the `stop_enter` cycle.
- R10: Writes to either register are ignored while STOP is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| cfg_wr | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control write data (bits 6..2 used) |
| ext_wr | input | 1 | Extension register write strobe |
| ext_wdata | input | 2 | Extension source select |
| stop_enter | input | 1 | One-cycle strobe that enters STOP |
| p2_in | input | 8 | Port 2 pins, asynchronous |
| p3_in | input | 4 | Port 3 pins 0..3, asynchronous |
| wake_req | output | 1 | One-cycle wake request |
| core_hold | output | 1 | Core reset hold after a delayed wake |
| cfg_rdata | output | 8 | Control register readback with status in bit 7 |

## Verification
The assertions check on every cycle that `wake_req` is a single pulse that only ends an active STOP. They also check that the registers are frozen during STOP, that the status bit is sticky and set by entry, and that a hold always starts with a delayed wake. Only the bench scenarios can show the source decoding for each encoding, the polarity, and the exact wake latency through the synchroniser and the qualification count. The same holds for the rejection of short pulses, the hold length and the cold/warm readback across power-on resets.

// File: rtl/swc_pkg.sv
package swc_pkg;
  localparam int P2_W = 8;
  localparam int P3_W = 4;

  typedef enum logic [2:0] {
    SRC_NONE    = 3'd0,
    SRC_P30     = 3'd1,
    SRC_P31     = 3'd2,
    SRC_P32     = 3'd3,
    SRC_P33     = 3'd4,
    SRC_P27     = 3'd5,
    SRC_NOR_LO  = 3'd6,
    SRC_NOR_ALL = 3'd7
  } src_e;

  typedef enum logic [1:0] {
    EXT_NONE    = 2'd0,
    EXT_AND_LO  = 2'd1,
    EXT_AND_ALL = 2'd2,
    EXT_RSVD    = 2'd3
  } ext_e;

  typedef struct packed {
    logic pol;
    logic dly;
    src_e src;
  } cfg_t;

  localparam cfg_t CFG_RST = '{pol: 1'b0, dly: 1'b1, src: SRC_NONE};
endpackage

// File: rtl/swc_sync.sv
module swc_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stg[g] <= '0;
          else        stg[g] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stg[g] <= '0;
          else        stg[g] <= stg[g-1];
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/swc_src_sel.sv
module swc_src_sel
  import swc_pkg::*;
(
  input  cfg_t             cfg,
  input  ext_e             ext,
  input  logic [P2_W-1:0]  p2,
  input  logic [P3_W-1:0]  p3,
  output logic             src_act
);
  logic hit;
  logic present;

  always_comb begin
    hit     = 1'b0;
    present = 1'b1;
    unique case (cfg.src)
      SRC_NONE: begin
        unique case (ext)
          EXT_AND_LO:  hit = &p2[3:0];
          EXT_AND_ALL: hit = &p2;
          default:     present = 1'b0;
        endcase
      end
      SRC_P30:     hit = p3[0];
      SRC_P31:     hit = p3[1];
      SRC_P32:     hit = p3[2];
      SRC_P33:     hit = p3[3];
      SRC_P27:     hit = p2[7];
      SRC_NOR_LO:  hit = ~|p2[3:0];
      SRC_NOR_ALL: hit = ~|p2;
      default:     present = 1'b0;
    endcase
  end

  // A missing source never wakes, whatever the polarity.
  assign src_act = present & (cfg.pol ? hit : ~hit);
endmodule

// File: rtl/swc_qual.sv
module swc_qual #(
  parameter int FAST_QUAL = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stop_enter,
  input  logic fast,
  input  logic src_act,
  output logic stop_act,
  output logic wake_fire,
  output logic wake_req
);
  localparam int CW = $clog2(FAST_QUAL + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] need;

  assign need      = fast ? CW'(FAST_QUAL) : CW'(1);
  assign wake_fire = stop_act & src_act & (cnt == need - CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stop_act <= 1'b0;
      cnt      <= '0;
      wake_req <= 1'b0;
    end else begin
      wake_req <= wake_fire;
      if (wake_fire) begin
        stop_act <= 1'b0;
        cnt      <= '0;
      end else begin
        if (stop_enter) stop_act <= 1'b1;
        cnt <= (stop_act && src_act) ? cnt + CW'(1) : '0;
      end
    end
  end

  // R8: the wake request is a single pulse
  p_wake_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |=> !wake_req);
  // R8: a wake only ends an active STOP
  p_wake_ends_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> ($past(stop_act) && !stop_act));
  // R6: the source was active in the accepting cycle
  p_wake_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> $past(src_act));
endmodule

// File: rtl/swc_hold_timer.sv
module swc_hold_timer #(
  parameter int DLY_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic hold
);
  generate
    if (DLY_CYCLES == 0) begin : g_none
      assign hold = 1'b0;
    end else begin : g_cnt
      localparam int TW = $clog2(DLY_CYCLES + 1);
      logic [TW-1:0] left;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              left <= '0;
        else if (start)          left <= TW'(DLY_CYCLES);
        else if (left != '0)     left <= left - TW'(1);
      end
      assign hold = (left != '0);

      // R5: a delayed wake raises the hold in the next cycle
      p_hold_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> hold);
    end
  endgenerate

  // R5: the hold never rises without a start
  p_hold_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && !start) |=> !hold);
endmodule

// File: rtl/stop_wake_ctrl.sv
module stop_wake_ctrl
  import swc_pkg::*;
#(
  parameter int DLY_CYCLES  = 16,
  parameter int FAST_QUAL   = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        por_n,
  input  logic        cfg_wr,
  input  logic [7:0]  cfg_wdata,
  input  logic        ext_wr,
  input  logic [1:0]  ext_wdata,
  input  logic        stop_enter,
  input  logic [7:0]  p2_in,
  input  logic [3:0]  p3_in,
  output logic        wake_req,
  output logic        core_hold,
  output logic [7:0]  cfg_rdata
);
  cfg_t            cfg_q;
  ext_e            ext_q;
  logic            warm_q;
  logic            stop_act;
  logic            wake_fire;
  logic            src_act;
  logic [P2_W-1:0] p2_s;
  logic [P3_W-1:0] p3_s;
  logic            unused_wbits;

  assign unused_wbits = ^{cfg_wdata[7], cfg_wdata[1:0]};

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cfg_q  <= CFG_RST;
      ext_q  <= EXT_NONE;
      warm_q <= 1'b0;
    end else begin
      if (cfg_wr && !stop_act) cfg_q <= cfg_t'(cfg_wdata[6:2]);
      if (ext_wr && !stop_act) ext_q <= ext_e'(ext_wdata);
      if (stop_enter)          warm_q <= 1'b1;
    end
  end

  swc_sync #(.W(P2_W + P3_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (por_n),
    .d     ({p2_in, p3_in}),
    .q     ({p2_s, p3_s})
  );

  swc_src_sel u_sel (
    .cfg     (cfg_q),
    .ext     (ext_q),
    .p2      (p2_s),
    .p3      (p3_s),
    .src_act (src_act)
  );

  swc_qual #(.FAST_QUAL(FAST_QUAL)) u_qual (
    .clk        (clk),
    .rst_n      (por_n),
    .stop_enter (stop_enter),
    .fast       (~cfg_q.dly),
    .src_act    (src_act),
    .stop_act   (stop_act),
    .wake_fire  (wake_fire),
    .wake_req   (wake_req)
  );

  swc_hold_timer #(.DLY_CYCLES(DLY_CYCLES)) u_hold (
    .clk   (clk),
    .rst_n (por_n),
    .start (wake_fire & cfg_q.dly),
    .hold  (core_hold)
  );

  assign cfg_rdata = {warm_q, cfg_q, 2'b00};

  // R10: registers stay frozen while STOP is active
  p_cfg_frozen_r10: assert property (@(posedge clk) disable iff (!por_n)
    stop_act |=> ($stable(cfg_q) && $stable(ext_q)));
  // R7: the warm flag is sticky until power-on reset
  p_warm_sticky_r7: assert property (@(posedge clk) disable iff (!por_n)
    warm_q |=> warm_q);
  // R7: STOP entry marks a warm start
  p_warm_set_r7: assert property (@(posedge clk) disable iff (!por_n)
    stop_enter |=> warm_q);
endmodule

// File: tb/stop_wake_ctrl_bench.sv
module stop_wake_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DLY = 16;
  localparam int FQ  = 5;

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic cfg_wr = 1'b0, ext_wr = 1'b0, stop_enter = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic [1:0] ext_wdata = '0;
  logic [7:0] p2_in = '0;
  logic [3:0] p3_in = '0;
  logic wake_req, core_hold;
  logic [7:0] cfg_rdata;
  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stop_wake_ctrl #(.DLY_CYCLES(DLY), .FAST_QUAL(FQ)) u_stop_wake_ctrl (
    .clk, .por_n, .cfg_wr, .cfg_wdata, .ext_wr, .ext_wdata, .stop_enter,
    .p2_in, .p3_in, .wake_req, .core_hold, .cfg_rdata);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit exp_active(input logic [7:0] c, input logic [1:0] e,
                                    input logic [7:0] p2, input logic [3:0] p3);
    logic v;
    case (c[4:2])
      3'd0: begin
        if (e == 2'd1)      v = &p2[3:0];
        else if (e == 2'd2) v = &p2;
        else return 1'b0;
      end
      3'd1: v = p3[0];
      3'd2: v = p3[1];
      3'd3: v = p3[2];
      3'd4: v = p3[3];
      3'd5: v = p2[7];
      3'd6: v = ~|p2[3:0];
      default: v = ~|p2;
    endcase
    return c[6] ? v : ~v;
  endfunction

  task automatic por();
    @(negedge clk); por_n = 1'b0;
    repeat (2) @(negedge clk);
    por_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] c, input logic [1:0] e);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_wdata = c; ext_wr = 1'b1; ext_wdata = e;
    @(negedge clk);
    cfg_wr = 1'b0; ext_wr = 1'b0;
  endtask

  // Waits up to maxc cycles, returns first sample index with wake_req, 0 if none.
  task automatic watch(input int maxc, input bit drop_stop, output int at);
    at = 0;
    for (int i = 1; i <= maxc; i++) begin
      @(negedge clk);
      if (i == 1 && drop_stop) stop_enter = 1'b0;
      if (wake_req && at == 0) at = i;
    end
  endtask

  task automatic hold_len(output int len);
    len = 0;
    for (int i = 0; i < DLY + 8; i++) begin
      if (core_hold) len++;
      @(negedge clk);
    end
  endtask

  task automatic trial(input logic [7:0] c, input logic [1:0] e,
                       input logic [7:0] p2, input logic [3:0] p3);
    bit act; int need, at, exp_at, len;
    wr(c, e);
    p2_in = p2; p3_in = p3;
    repeat (4) @(negedge clk);
    act  = exp_active(c, e, p2, p3);
    need = c[5] ? 1 : FQ;
    exp_at = act ? 1 + need : 0;
    stop_enter = 1'b1;
    // R2 R3 R4 R9: source decode, polarity and entry latency
    watch(12, 1'b1, at);
    check(at == exp_at, "R2/R3/R4/R9 wake cycle", at, exp_at);
    check(cfg_rdata[7] == 1'b1, "R7 warm after stop entry", cfg_rdata[7], 1);
    if (act) begin
      // R5 hold length / R6 none in fast mode; re-align to the wake cycle
      if (c[5]) begin
        wr(c, e);
        p2_in = p2; p3_in = p3;
        @(negedge clk); stop_enter = 1'b1;
        @(negedge clk); stop_enter = 1'b0;
        @(negedge clk);
        hold_len(len);
        check(len == DLY, "R5 hold length", len, DLY);
      end else begin
        check(core_hold == 1'b0, "R6 no hold in fast mode", core_hold, 0);
      end
    end else begin
      por();
      check(cfg_rdata == 8'h20, "R7 cold after power-on", cfg_rdata, 8'h20);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int at, seed_dummy;
    logic [7:0] c, p2;
    seed_dummy = $urandom(32'h5eed_1234);
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(cfg_rdata == 8'h20, "R1 reset readback", cfg_rdata, 8'h20);
    check(wake_req == 1'b0, "R1 wake idle", wake_req, 0);
    check(core_hold == 1'b0, "R1 hold idle", core_hold, 0);

    // R10: writes during STOP are ignored
    @(negedge clk); stop_enter = 1'b1;
    @(negedge clk); stop_enter = 1'b0;
    wr(8'h44, 2'd1);
    check(cfg_rdata == 8'hA0, "R10 write ignored in stop", cfg_rdata, 8'hA0);
    p2_in = 8'hFF;
    watch(8, 1'b0, at);
    check(at == 0, "R10 ext write ignored, no wake", at, 0);
    por();
    check(cfg_rdata == 8'h20, "R7 cold after por", cfg_rdata, 8'h20);

    // R6: short pulse rejected in fast mode, then R9 pin-change latency
    wr(8'h44, 2'd0);
    p2_in = 8'h00; p3_in = 4'h0;
    @(negedge clk); stop_enter = 1'b1;
    @(negedge clk); stop_enter = 1'b0;
    @(negedge clk); p3_in = 4'h1;
    repeat (FQ - 2) @(negedge clk);
    p3_in = 4'h0;
    watch(10, 1'b0, at);
    check(at == 0, "R6 short pulse no wake", at, 0);
    p3_in = 4'h1;
    watch(12, 1'b0, at);
    check(at == 2 + FQ, "R9 fast wake latency", at, 2 + FQ);
    check(core_hold == 1'b0, "R6 hold stays low", core_hold, 0);
    check(cfg_rdata[7] == 1'b1, "R7 warm kept after wake", cfg_rdata[7], 1);

    // R8: after a wake STOP is over; active source gives no second wake
    watch(8, 1'b0, at);
    check(at == 0, "R8 no wake outside stop", at, 0);

    // R9 delayed-mode pin latency and R5 hold
    wr(8'h64, 2'd0);
    p3_in = 4'h0;
    @(negedge clk); stop_enter = 1'b1;
    @(negedge clk); stop_enter = 1'b0;
    @(negedge clk); p3_in = 4'h1;
    watch(3, 1'b0, at);
    check(at == 3, "R9 delayed wake latency", at, 3);
    check(core_hold == 1'b1, "R5 hold rises with wake", core_hold, 1);

    // R4 directed: extension ignored with a pin source; code 11 no source
    trial(8'h44, 2'd1, 8'hFF, 4'h0);
    trial(8'h60, 2'd3, 8'hFF, 4'h0);
    trial(8'h20, 2'd3, 8'h00, 4'h0);
    trial(8'h60, 2'd2, 8'hFF, 4'h0);
    trial(8'h40, 2'd1, 8'h0F, 4'h0);

    // Random mix of all encodings
    for (int k = 0; k < 40; k++) begin
      c  = 8'($urandom) & 8'h7C;
      case ($urandom % 4)
        0: p2 = 8'hFF;
        1: p2 = 8'h00;
        2: p2 = 8'h0F;
        default: p2 = 8'($urandom);
      endcase
      trial(c, 2'($urandom), p2, 4'($urandom));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule